// File: doc/BRIEF.md
# Directional Message RAM Pair

This block holds two small shared RAMs through which a host CPU and an accelerator core exchange messages. One RAM carries traffic from the accelerator to the host (the "up" RAM) and the other from the host to the accelerator (the "down" RAM). Each side has its own port with an address, read and write strobes, a width select, an access-type flag that marks an instruction fetch, write data, read data and an error output. Both RAMs are visible through both ports at all times, so no mapping setup is needed.

Write permission is fixed by direction. Only the accelerator may write the up RAM, and only the host may write the down RAM. A write from the consuming side completes like any other write, but the stored word is left untouched and no error is raised. The RAMs hold data only. Any access flagged as a fetch is refused: it returns zero and raises a one-cycle error pulse on the port that asked for it.

Storage is organised as 32-bit words made of two 16-bit halves. Reads are synchronous, with one cycle of latency, and both ports can read in the same cycle.

Top module: `msgRamPair`

## Requirements
- R1: After reset, both read data outputs are zero and both error outputs are low.
- R2: An accelerator write to the up RAM (address top bit 0) is stored, and both ports read the stored value back.
- R3: A host write to the up RAM leaves the stored word unchanged and does not raise hostErr.
- R4: A host write to the down RAM (address top bit 1) is stored, and both ports read the stored value back.
- R5: An accelerator write to the down RAM leaves the stored word unchanged and does not raise accErr.
- R6: An access with the fetch flag set, to either RAM, writes nothing and returns zero read data. It also raises the port's error output for exactly the one cycle after the request.
- R7: Read data appears on the cycle after the read strobe. A read of the word being written in that same cycle returns the old contents.
- R8: Both ports can read the same RAM in the same cycle, and each gets its own correct data.
- R9: Address bit 0 selects the half of a 32-bit word. A half write (wide=0) stores wdata[15:0] in the selected half only. A half read returns the selected half in bits 15:0, with bits 31:16 zero.
- R10: A word access (wide=1) ignores address bit 0. A word write updates both halves in one cycle from wdata[31:0], and a word read returns {upper half, lower half}.
- R11: When a port does not read, its read data output holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | ADDR_W (6) | Host address: top bit selects the RAM, bits [ADDR_W-2:1] select the word, bit 0 selects the half |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| hostWide | input | 1 | Host access is a 32-bit word (1) or a 16-bit half (0) |
| hostFetch | input | 1 | Host access is an instruction fetch |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, registered |
| hostErr | output | 1 | Host refused-fetch pulse |
| accAddr | input | ADDR_W (6) | Accelerator address, same layout as hostAddr |
| accRd | input | 1 | Accelerator read strobe |
| accWr | input | 1 | Accelerator write strobe |
| accWide | input | 1 | Accelerator word (1) or half (0) access |
| accFetch | input | 1 | Accelerator access is an instruction fetch |
| accWdata | input | 32 | Accelerator write data |
| accRdata | output | 32 | Accelerator read data, registered |
| accErr | output | 1 | Accelerator refused-fetch pulse |

## Verification
Two things can land on the same RAM word in one cycle: the producer's write and a read from the consumer, or a consumer write that must be dropped. The bench drives the accelerator's write and the host's read of that same up-RAM word at one clock edge. It expects the old word in that cycle and the new word on a later read. It also drives dual reads of one word from both ports at once, and judges each port's data separately against the value the bench tracks for that word.

// File: rtl/msgRamPkg.sv
package msgRamPkg;

  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam logic UP_RAM = 1'b0;   // accelerator -> host
  localparam logic DN_RAM = 1'b1;   // host -> accelerator

  typedef struct packed {
    logic rdEn;      // plain data read
    logic rdRam;     // which RAM is read
    logic rdWide;    // word read
    logic rdHalf;    // half select for half reads
    logic fetchErr;  // refused fetch
  } portStbT;

  typedef struct packed {
    logic wrLo;
    logic wrHi;
  } ramWrT;

  typedef struct packed {
    portStbT host;
    portStbT acc;
    ramWrT   up;
    ramWrT   dn;
  } ctrlStbT;

endpackage

// File: rtl/msgRamCtrl.sv
module msgRamCtrl
  import msgRamPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostSel,
  input  logic    hostHalf,
  input  logic    hostRd,
  input  logic    hostWr,
  input  logic    hostWide,
  input  logic    hostFetch,
  input  logic    accSel,
  input  logic    accHalf,
  input  logic    accRd,
  input  logic    accWr,
  input  logic    accWide,
  input  logic    accFetch,
  output ctrlStbT stb
);

  function automatic portStbT decodeRead(input logic sel, input logic half,
                                         input logic rd, input logic wr,
                                         input logic wide, input logic fetch);
    portStbT s;
    s.fetchErr = fetch && (rd || wr);
    s.rdEn     = rd && !fetch;
    s.rdRam    = sel;
    s.rdWide   = wide;
    s.rdHalf   = half;
    return s;
  endfunction

  function automatic ramWrT decodeWrite(input logic ownerWr, input logic ownerFetch,
                                        input logic sel, input logic target,
                                        input logic half, input logic wide);
    ramWrT w;
    logic  go;
    go     = ownerWr && !ownerFetch && (sel == target);
    w.wrLo = go && (wide || !half);
    w.wrHi = go && (wide || half);
    return w;
  endfunction

  always_comb begin
    stb.host = decodeRead(hostSel, hostHalf, hostRd, hostWr, hostWide, hostFetch);
    stb.acc  = decodeRead(accSel, accHalf, accRd, accWr, accWide, accFetch);
    // Producer side only: consumer writes never reach a write enable.
    stb.up   = decodeWrite(accWr, accFetch, accSel, UP_RAM, accHalf, accWide);
    stb.dn   = decodeWrite(hostWr, hostFetch, hostSel, DN_RAM, hostHalf, hostWide);
  end

  AST_UP_ONLY_ACC: assert property (@(posedge clk) disable iff (!rstN)
    (stb.up.wrLo || stb.up.wrHi) |-> (accWr && !accFetch && accSel == UP_RAM)); // R3
  AST_DN_ONLY_HOST: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dn.wrLo || stb.dn.wrHi) |-> (hostWr && !hostFetch && hostSel == DN_RAM)); // R5

endmodule

// File: rtl/msgRamDp.sv
module msgRamDp
  import msgRamPkg::*;
#(
  parameter int WORD_AW = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStbT            stb,
  input  logic [WORD_AW-1:0] hostIdx,
  input  logic [WORD_W-1:0]  hostWdata,
  input  logic [WORD_AW-1:0] accIdx,
  input  logic [WORD_W-1:0]  accWdata,
  output logic [WORD_W-1:0]  hostRdata,
  output logic               hostErr,
  output logic [WORD_W-1:0]  accRdata,
  output logic               accErr
);

  localparam int DEPTH = 1 << WORD_AW;
  localparam int NPORT = 2;   // 0 = host, 1 = accelerator
  localparam int NRAM  = 2;   // 0 = up, 1 = down

  logic [WORD_AW-1:0] pIdx   [NPORT];
  logic [WORD_W-1:0]  pWdata [NPORT];
  portStbT            pStb   [NPORT];
  ramWrT              rWr    [NRAM];
  logic [WORD_W-1:0]  rdWord [NRAM][NPORT];
  logic [WORD_W-1:0]  pRdata [NPORT];
  logic               pErr   [NPORT];

  assign pIdx[0]   = hostIdx;
  assign pIdx[1]   = accIdx;
  assign pWdata[0] = hostWdata;
  assign pWdata[1] = accWdata;
  assign pStb[0]   = stb.host;
  assign pStb[1]   = stb.acc;
  assign rWr[0]    = stb.up;
  assign rWr[1]    = stb.dn;

  for (genvar r = 0; r < NRAM; r++) begin : g_ram
    localparam int OWNER = (r == 0) ? 1 : 0;   // up RAM owned by acc, down by host
    logic [HALF_W-1:0] loMem [DEPTH];
    logic [HALF_W-1:0] hiMem [DEPTH];
    logic [HALF_W-1:0] loData;
    logic [HALF_W-1:0] hiData;

    // A half write always carries its data in bits 15:0.
    assign loData = pWdata[OWNER][HALF_W-1:0];
    assign hiData = (rWr[r].wrLo && rWr[r].wrHi) ? pWdata[OWNER][WORD_W-1:HALF_W]
                                                 : pWdata[OWNER][HALF_W-1:0];

    always_ff @(posedge clk) begin
      if (rWr[r].wrLo) loMem[pIdx[OWNER]] <= loData;
      if (rWr[r].wrHi) hiMem[pIdx[OWNER]] <= hiData;
    end

    for (genvar q = 0; q < NPORT; q++) begin : g_rd
      assign rdWord[r][q] = {hiMem[pIdx[q]], loMem[pIdx[q]]};
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [WORD_W-1:0] word;
    assign word = rdWord[pStb[p].rdRam][p];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pRdata[p] <= '0;
        pErr[p]   <= 1'b0;
      end else begin
        pErr[p] <= pStb[p].fetchErr;
        if (pStb[p].fetchErr)
          pRdata[p] <= '0;
        else if (pStb[p].rdEn)
          pRdata[p] <= pStb[p].rdWide ? word
                     : {{HALF_W{1'b0}}, pStb[p].rdHalf ? word[WORD_W-1:HALF_W]
                                                       : word[HALF_W-1:0]};
      end
    end

    AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      pErr[p] |-> (pRdata[p] == '0)); // R6
    AST_ERR_FOLLOWS_FETCH: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pErr[p]) |-> $past(pStb[p].fetchErr)); // R6
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (!pStb[p].rdEn && !pStb[p].fetchErr) |=> $stable(pRdata[p])); // R11
    AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (pStb[p].rdEn && !pStb[p].fetchErr && !pStb[p].rdWide)
        |=> (pRdata[p][WORD_W-1:HALF_W] == '0)); // R9
  end

  assign hostRdata = pRdata[0];
  assign hostErr   = pErr[0];
  assign accRdata  = pRdata[1];
  assign accErr    = pErr[1];

endmodule

// File: rtl/msgRamPair.sv
module msgRamPair
  import msgRamPkg::*;
#(
  parameter int WORD_AW = 4,
  parameter int ADDR_W  = WORD_AW + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic              hostWide,
  input  logic              hostFetch,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic              hostErr,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accRd,
  input  logic              accWr,
  input  logic              accWide,
  input  logic              accFetch,
  input  logic [31:0]       accWdata,
  output logic [31:0]       accRdata,
  output logic              accErr
);

  ctrlStbT stb;

  msgRamCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostSel  (hostAddr[ADDR_W-1]),
    .hostHalf (hostAddr[0]),
    .hostRd   (hostRd),
    .hostWr   (hostWr),
    .hostWide (hostWide),
    .hostFetch(hostFetch),
    .accSel   (accAddr[ADDR_W-1]),
    .accHalf  (accAddr[0]),
    .accRd    (accRd),
    .accWr    (accWr),
    .accWide  (accWide),
    .accFetch (accFetch),
    .stb      (stb)
  );

  msgRamDp #(.WORD_AW(WORD_AW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .hostIdx  (hostAddr[ADDR_W-2:1]),
    .hostWdata(hostWdata),
    .accIdx   (accAddr[ADDR_W-2:1]),
    .accWdata (accWdata),
    .hostRdata(hostRdata),
    .hostErr  (hostErr),
    .accRdata (accRdata),
    .accErr   (accErr)
  );

endmodule

// File: tb/msgRamPair_tb.sv
module msgRamPair_tb;

  localparam int WAW = 4;
  localparam int AW  = WAW + 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] hostAddr = '0, accAddr = '0;
  logic          hostRd = 0, hostWr = 0, hostWide = 0, hostFetch = 0;
  logic          accRd = 0, accWr = 0, accWide = 0, accFetch = 0;
  logic [31:0]   hostWdata = '0, accWdata = '0;
  logic [31:0]   hostRdata, accRdata;
  logic          hostErr, accErr;

  int vectors = 0;
  int misses  = 0;

  always #10 clk = ~clk;   // 50 MHz

  msgRamPair #(.WORD_AW(WAW)) u_dut (.*);

  function automatic logic [AW-1:0] mkA(input logic ram, input int idx, input logic half);
    return {ram, idx[WAW-1:0], half};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostCmd(input logic rd, input logic wr, input logic wide,
                         input logic fetch, input logic [AW-1:0] a, input logic [31:0] d);
    hostRd = rd; hostWr = wr; hostWide = wide; hostFetch = fetch; hostAddr = a; hostWdata = d;
  endtask

  task automatic accCmd(input logic rd, input logic wr, input logic wide,
                        input logic fetch, input logic [AW-1:0] a, input logic [31:0] d);
    accRd = rd; accWr = wr; accWide = wide; accFetch = fetch; accAddr = a; accWdata = d;
  endtask

  // Wait for the edge that consumes the commands, then return the ports to idle.
  task automatic step();
    @(negedge clk);
    hostCmd(0, 0, 0, 0, '0, '0);
    accCmd(0, 0, 0, 0, '0, '0);
  endtask

  task automatic t_reset();
    chk("R1 hostRdata", hostRdata, 32'h0);
    chk("R1 accRdata", accRdata, 32'h0);
    chk("R1 errs", {30'b0, hostErr, accErr}, 32'h0);
  endtask

  task automatic t_upRam();
    accCmd(0, 1, 1, 0, mkA(0, 3, 0), 32'hA5A5_1234); step();
    hostCmd(1, 0, 1, 0, mkA(0, 3, 0), '0);
    accCmd(1, 0, 1, 0, mkA(0, 3, 0), '0); step();
    chk("R2 host reads up", hostRdata, 32'hA5A5_1234);
    chk("R2 R8 acc reads up same cycle", accRdata, 32'hA5A5_1234);
  endtask

  task automatic t_hostWrUp();
    hostCmd(0, 1, 1, 0, mkA(0, 3, 0), 32'hDEAD_BEEF); step();
    chk("R3 no hostErr", {31'b0, hostErr}, 32'h0);
    hostCmd(1, 0, 1, 0, mkA(0, 3, 0), '0); step();
    chk("R3 up word unchanged", hostRdata, 32'hA5A5_1234);
  endtask

  task automatic t_dnRam();
    hostCmd(0, 1, 1, 0, mkA(1, 5, 0), 32'h0BAD_CAFE); step();
    accCmd(1, 0, 1, 0, mkA(1, 5, 0), '0);
    hostCmd(1, 0, 1, 0, mkA(1, 5, 0), '0); step();
    chk("R4 acc reads down", accRdata, 32'h0BAD_CAFE);
    chk("R4 R8 host reads down same cycle", hostRdata, 32'h0BAD_CAFE);
  endtask

  task automatic t_accWrDn();
    accCmd(0, 1, 1, 0, mkA(1, 5, 0), 32'h1357_9BDF); step();
    chk("R5 no accErr", {31'b0, accErr}, 32'h0);
    accCmd(1, 0, 1, 0, mkA(1, 5, 0), '0); step();
    chk("R5 down word unchanged", accRdata, 32'h0BAD_CAFE);
  endtask

  task automatic t_fetch();
    hostCmd(1, 0, 1, 1, mkA(0, 3, 0), '0);
    accCmd(1, 0, 1, 1, mkA(1, 5, 0), '0); step();
    chk("R6 host fetch zero", hostRdata, 32'h0);
    chk("R6 acc fetch zero", accRdata, 32'h0);
    chk("R6 both err high", {30'b0, hostErr, accErr}, 32'h3);
    step();
    chk("R6 err one cycle", {30'b0, hostErr, accErr}, 32'h0);
    accCmd(0, 1, 1, 1, mkA(0, 3, 0), 32'hFFFF_FFFF); step();
    chk("R6 fetch write err", {31'b0, accErr}, 32'h1);
    accCmd(1, 0, 1, 0, mkA(0, 3, 0), '0); step();
    chk("R6 fetch write dropped", accRdata, 32'hA5A5_1234);
  endtask

  task automatic t_rdDuringWr();
    accCmd(0, 1, 1, 0, mkA(0, 3, 0), 32'h1111_2222);
    hostCmd(1, 0, 1, 0, mkA(0, 3, 0), '0); step();
    chk("R7 old data on same-cycle read", hostRdata, 32'hA5A5_1234);
    hostCmd(1, 0, 1, 0, mkA(0, 3, 0), '0); step();
    chk("R7 new data next read", hostRdata, 32'h1111_2222);
  endtask

  task automatic t_half();
    accCmd(0, 1, 1, 0, mkA(0, 7, 0), 32'h1234_5678); step();
    accCmd(0, 1, 0, 0, mkA(0, 7, 0), 32'h0000_BEEF); step();
    hostCmd(1, 0, 1, 0, mkA(0, 7, 0), '0); step();
    chk("R9 half write lower only", hostRdata, 32'h1234_BEEF);
    accCmd(0, 1, 0, 0, mkA(0, 7, 1), 32'hFFFF_7777); step();
    hostCmd(1, 0, 0, 0, mkA(0, 7, 1), '0);
    accCmd(1, 0, 0, 0, mkA(0, 7, 0), '0); step();
    chk("R9 half read upper", hostRdata, 32'h0000_7777);
    chk("R9 half read lower", accRdata, 32'h0000_BEEF);
  endtask

  task automatic t_wide();
    hostCmd(0, 1, 1, 0, mkA(1, 9, 1), 32'hCAFE_F00D); step();
    accCmd(1, 0, 1, 0, mkA(1, 9, 1), '0);
    hostCmd(1, 0, 0, 0, mkA(1, 9, 0), '0); step();
    chk("R10 word read both halves", accRdata, 32'hCAFE_F00D);
    chk("R10 lower half of word write", hostRdata, 32'h0000_F00D);
  endtask

  task automatic t_hold();
    hostCmd(1, 0, 1, 0, mkA(1, 5, 0), '0); step();
    accCmd(0, 1, 1, 0, mkA(0, 3, 0), 32'h5555_AAAA); step();
    step();
    chk("R11 host data held", hostRdata, 32'h0BAD_CAFE);
    chk("R11 acc data held", accRdata, 32'hCAFE_F00D);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        t_reset();
        t_upRam();
        t_hostWrUp();
        t_dnRam();
        t_accWrDn();
        t_fetch();
        t_rdDuringWr();
        t_half();
        t_wide();
        t_hold();
      end
      begin
        repeat (5000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule